// File: doc/BRIEF.md
# Half-Rate Direct Digital Synthesis Sine Core

This block is the digital heart of a programmable sine source. A 16-bit frequency word sets the step that a 21-bit phase register gains on every second clock cycle. The nine most significant phase bits select one of 512 points of a full sine cycle. The selected point leaves the block each clock as an 8-bit offset-binary sample that an external converter can take directly.

The sample rate is one sample per clock. The phase moves at half the clock rate, so the output frequency is `f_clk * word / 2^22`. The smallest nonzero step is `f_clk / 2^22`. A word of zero freezes the phase and gives a constant level. The usable upper limit is near `f_clk / 64`. An active-low alignment input clears the phase and the half-rate toggle while it is held low, and mutes the output to mid-scale. Several cores released from it on the same edge therefore run in lockstep. A shutdown input mutes the output without disturbing the phase.

Top module: `dds_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the phase and the half-rate toggle clear, and `sample_o` reads 128 after that edge.
- R2: After reset or alignment release, the phase stays put on the first edge and gains `freq_word` on the second edge, then alternates in the same way. `sample_o` shows the table entry for phase bits [20:12] as they stood before the edge that loads `sample_o`, so the output trails the phase by one clock.
- R3: The phase wraps modulo 2^21, so a word D that divides 2^21 repeats the output every 2^22/D clocks. For example, D = 4096 gives a period of 1024 clocks.
- R4: For a table address a, let p = a mod 256 and q = p*(256-p). The entry is 128+m for a < 256 and 128-m for a >= 256, where m = floor((4064*q + d) / (2*d)) and d = 327680 - 4*q. Every entry therefore lies in 1..255.
- R5: While `sync_n` is low at an edge, the phase and the toggle clear and `sample_o` reads 128 after that edge. Output resumes from phase zero with the R2 timing.
- R6: While `shdn` is high at an edge, `sample_o` reads 128 after that edge. The phase keeps advancing, so when `shdn` falls the output continues from the advanced phase.
- R7: With `freq_word` equal to zero, the phase holds and `sample_o` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the sample rate, and twice the phase update rate |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_word | input | 16 | Phase step added on each advance cycle |
| sync_n | input | 1 | Active-low alignment: clears the phase and mutes the output |
| shdn | input | 1 | High mutes the output to mid-scale |
| sample_o | output | 8 | Offset-binary sine sample, mid-scale 128 |

## Verification
The bench builds the core with its default widths: a 16-bit word, a 21-bit phase, 512 table points and 8-bit samples. These widths make a word of 4096 step through every table address in turn, once every two clocks. That exposes the whole table against the closed-form entry rule and gives a full period of 1024 clocks that can be checked directly. A word of 0xFFFF exercises repeated phase wrap. Alignment and shutdown pulses placed mid-run show the restart timing from phase zero and show that the phase runs on under shutdown.

// File: rtl/dds_pkg.sv
// dds_pkg: shared constants and the sine-entry function for the DDS core.
// Assumes the phase address splits into one half-cycle bit plus a magnitude
// index; the entry uses a rational sine approximation evaluated with integers.
package dds_pkg;

    // Mid-scale code for a sample of width w.
    function automatic int unsigned mid_code(input int unsigned w);
        return 32'd1 << (w - 1);
    endfunction

    // Sine entry for table address idx, address width aw, sample width sw.
    function automatic int unsigned sine_code(input int unsigned idx,
                                              input int unsigned aw,
                                              input int unsigned sw);
        longint unsigned half_pts;
        longint unsigned p;
        longint unsigned q;
        longint unsigned den;
        longint unsigned amp16;
        longint unsigned mag;
        half_pts = 64'd1 << (aw - 1);
        p        = longint'(idx) % half_pts;
        q        = p * (half_pts - p);
        den      = 5 * half_pts * half_pts - 4 * q;
        amp16    = 16 * (longint'(mid_code(sw)) - 1);
        mag      = (2 * amp16 * q + den) / (2 * den);
        if (longint'(idx) < half_pts)
            return mid_code(sw) + int'(mag);
        else
            return mid_code(sw) - int'(mag);
    endfunction

endpackage

// File: rtl/dds_tick_gen.sv
// dds_tick_gen: produces the advance enable that is high on every second clock.
// Assumes clr is synchronous; while clr is high the toggle holds at zero so the
// first advance after release lands on the second edge.
module dds_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic adv_o
);

    logic tog_q;

    // Toggle flop: cleared by reset or alignment, else inverts each clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            tog_q <= 1'b0;
        else
            tog_q <= ~tog_q;
    end

    assign adv_o = tog_q;

endmodule

// File: rtl/dds_phase_acc.sv
// dds_phase_acc: wrapping phase register that adds the frequency word when
// advance is high. Assumes ACC_W >= FREQ_W; the word is zero-extended.
module dds_phase_acc #(
    parameter int FREQ_W = 16,
    parameter int ACC_W  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [FREQ_W-1:0] freq,
    output logic [ACC_W-1:0]  phase_o
);

    localparam int PAD_W = ACC_W - FREQ_W;

    logic [ACC_W-1:0] phase_q;
    logic [ACC_W-1:0] step;

    // Zero-extend the word to the phase width.
    generate
        if (PAD_W > 0) begin : g_pad
            assign step = {{PAD_W{1'b0}}, freq};
        end else begin : g_nopad
            assign step = freq[ACC_W-1:0];
        end
    endgenerate

    // Phase register: cleared by reset or alignment, advances modulo 2^ACC_W.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            phase_q <= '0;
        else if (adv)
            phase_q <= phase_q + step;
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/dds_sine_rom.sv
// dds_sine_rom: full-cycle sine table computed at elaboration, read through one
// output register that can be muted to mid-scale. Assumes DEPTH = 2^ADDR_W.
module dds_sine_rom
    import dds_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mute,
    input  logic [ADDR_W-1:0]   addr,
    output logic [SAMPLE_W-1:0] sample_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(mid_code(SAMPLE_W));

    logic [SAMPLE_W-1:0] tbl [DEPTH];
    logic [SAMPLE_W-1:0] sample_q;

    // One constant entry per address.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
            localparam logic [SAMPLE_W-1:0] ENTRY =
                SAMPLE_W'(sine_code(i, ADDR_W, SAMPLE_W));
            assign tbl[i] = ENTRY;
        end
    endgenerate

    // Output register: mid-scale on reset or mute, else the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n || mute)
            sample_q <= MID;
        else
            sample_q <= tbl[addr];
    end

    assign sample_o = sample_q;

endmodule

// File: rtl/dds_core.sv
// dds_core: half-rate DDS top. A toggle gates the phase adder to alternate
// clocks; the upper phase bits address the sine table. Alignment (active low)
// clears phase and toggle and mutes; shutdown only mutes.
// Assumes all inputs are synchronous to clk.
module dds_core #(
    parameter int FREQ_W   = 16,
    parameter int ACC_W    = 21,
    parameter int ADDR_W   = 9,
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FREQ_W-1:0]   freq_word,
    input  logic                sync_n,
    input  logic                shdn,
    output logic [SAMPLE_W-1:0] sample_o
);

    localparam int ADDR_LSB = ACC_W - ADDR_W;

    logic              align;
    logic              adv_en;
    logic              mute;
    logic [ACC_W-1:0]  phase_q;
    logic [ADDR_W-1:0] tbl_addr;

    // Control decode: alignment clears state, either input mutes.
    assign align    = ~sync_n;
    assign mute     = align | shdn;
    assign tbl_addr = phase_q[ACC_W-1:ADDR_LSB];

    dds_tick_gen tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (align),
        .adv_o (adv_en)
    );

    dds_phase_acc #(
        .FREQ_W (FREQ_W),
        .ACC_W  (ACC_W)
    ) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (align),
        .adv     (adv_en),
        .freq    (freq_word),
        .phase_o (phase_q)
    );

    dds_sine_rom #(
        .ADDR_W   (ADDR_W),
        .SAMPLE_W (SAMPLE_W)
    ) rom_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mute     (mute),
        .addr     (tbl_addr),
        .sample_o (sample_o)
    );

endmodule

// File: rtl/dds_core_chk.sv
// dds_core_chk: temporal properties of dds_core, attached by bind below.
module dds_core_chk #(
    parameter int FREQ_W   = 16,
    parameter int ACC_W    = 21,
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [FREQ_W-1:0]   freq_word,
    input logic                sync_n,
    input logic                shdn,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                adv_en,
    input logic [ACC_W-1:0]    phase_q
);

    localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << (SAMPLE_W - 1));

    // R5
    sync_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |=> sample_o == MID);

    // R5
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |=> phase_q == '0 && !adv_en);

    // R6
    shdn_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> sample_o == MID);

    // R2
    alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |=> adv_en != $past(adv_en));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n && !adv_en |=> $stable(phase_q));

    // R7
    zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n && freq_word == '0 |=> $stable(phase_q));

    // R4
    always @(negedge clk) begin
        if (rst_n) begin
            sample_range_chk: assert (sample_o != '0);
        end
    end

endmodule

bind dds_core dds_core_chk #(
    .FREQ_W   (FREQ_W),
    .ACC_W    (ACC_W),
    .SAMPLE_W (SAMPLE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_word (freq_word),
    .sync_n    (sync_n),
    .shdn      (shdn),
    .sample_o  (sample_o),
    .adv_en    (adv_en),
    .phase_q   (phase_q)
);

// File: tb/dds_core_tb_top.sv
// Bench for dds_core: behavioural reference model stepped on each rising edge,
// compared with the DUT on each falling edge.
module dds_core_tb_top;

    localparam int PH_MOD = 1 << 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] freq_word = 16'h0000;
    logic        sync_n = 1'b1;
    logic        shdn = 1'b0;
    logic [7:0]  sample_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string tag = "R1";
    bit    done = 1'b0;

    int m_phase = 0;
    int m_tog = 0;
    int m_out = 128;

    always #5 clk = ~clk;

    dds_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .freq_word (freq_word),
        .sync_n    (sync_n),
        .shdn      (shdn),
        .sample_o  (sample_o)
    );

    // Sine entry as written in R4.
    function automatic int ref_entry(input int a);
        int p, q, d, m;
        p = a % 256;
        q = p * (256 - p);
        d = 327680 - 4 * q;
        m = (4064 * q + d) / (2 * d);
        return (a < 256) ? 128 + m : 128 - m;
    endfunction

    // Reference model step.
    always @(posedge clk) begin
        int nxt;
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_phase = 0; m_tog = 0; m_out = 128;
        end else begin
            nxt = (!sync_n || shdn) ? 128 : ref_entry(m_phase / 4096);
            if (!sync_n) begin
                m_phase = 0; m_tog = 0;
            end else begin
                if (m_tog == 1) m_phase = (m_phase + int'(freq_word)) % PH_MOD;
                m_tog = 1 - m_tog;
            end
            m_out = nxt;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (!done) check(tag, int'(sample_o), m_out);
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int v0;
        int hist[$];
        // R1: reset state
        tag = "R1";
        run(4);
        check("R1", int'(sample_o), 128);
        rst_n = 1'b1;
        // R2 / R4: word 4096 walks every table address
        tag = "R4";
        freq_word = 16'd4096;
        run(1100);
        // R3: 1024-clock period
        tag = "R3";
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk);
            hist.push_back(int'(sample_o));
        end
        for (int i = 0; i < 60; i++) check("R3", hist[i + 1024], hist[i]);
        check("R4", ref_entry(128), 255);
        check("R4", ref_entry(384), 1);
        // R3: repeated wrap at the largest word
        freq_word = 16'hFFFF;
        run(400);
        // R2: other words
        tag = "R2";
        freq_word = 16'h1234; run(300);
        freq_word = 16'h0001; run(50);
        freq_word = 16'h8000; run(100);
        // R7: zero word holds output
        tag = "R7";
        freq_word = 16'h3000; run(7);
        freq_word = 16'h0000; run(3);
        v0 = int'(sample_o);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check("R7", int'(sample_o), v0);
        end
        // R5: alignment pulse mid-run
        tag = "R5";
        freq_word = 16'h2000; run(37);
        sync_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R5", int'(sample_o), 128);
        end
        sync_n = 1'b1;
        run(200);
        // R6: shutdown keeps phase running
        tag = "R6";
        shdn = 1'b1;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            check("R6", int'(sample_o), 128);
        end
        shdn = 1'b0;
        run(200);
        // R1: reset mid-run
        tag = "R1";
        rst_n = 1'b0;
        run(2);
        check("R1", int'(sample_o), 128);
        rst_n = 1'b1;
        run(100);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule